// File: doc/BRIEF.md
# ISA-Style I/O Slave with Wait-State Insertion

This block sits on the bus side of an 8-bit I/O expansion card. It compares the full 16-bit I/O address against a fixed base and treats the card as addressed only when the DMA address-enable line is low. An addressed read command puts the selected register onto the low data byte, with an output enable. An addressed write command captures the low data byte into a small register file when the write strobe goes back high.

Each access holds the channel-ready line low from the first cycle of the command. The line stays low while a latency counter, loaded from a per-register configuration field, counts down to zero. It then stays low until the internal device reports that it is ready. The ready line is open drain, so the block only produces an enable that pulls it low.

All bus inputs are taken as already synchronous to `clk`. Strobes and reset are active low.

Top module: `isa_io_slave`

## Requirements
- R1: The card is addressed only when address bits 15..2 equal bits 15..2 of `BASE_ADDR` (default 16'h0300). Bits 1..0 select one of four registers. Aliases such as 16'h1300 and neighbours such as 16'h0304 are not addressed: they produce no data drive, no wait state and no register change.
- R2: While `aen` is high the card is never addressed, even at a matching address. No read data is driven, the ready line is not pulled low, and a write has no effect on the registers.
- R3: In an accepted write cycle, `sdIn` is stored into the addressed register at the clock edge that first samples `iowN` high again. A later read of that register returns the stored byte.
- R4: `sdOe` is high only while `iorN` is low and the card is addressed. While it is high, `sdOut` equals the addressed register.
- R5: `rdyLowEn` goes high in the same cycle that an addressed read or write command first appears. It is not delayed by a register.
- R6: With `devReady` held high, `rdyLowEn` stays high for exactly L+1 clock cycles of a command. L is the 4-bit field of `cfgLatency` at bits [4*i+3:4*i] for register i, taken when the command starts.
- R7: Once the counter has expired, `rdyLowEn` stays high for as long as `devReady` is low. It drops in the cycle `devReady` rises, and it stays low for the rest of that command.
- R8: After reset all four registers read as zero, and `sdOe` and `rdyLowEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are synchronous to it |
| rstN | input | 1 | Active-low synchronous reset |
| saAddr | input | 16 | I/O address |
| aen | input | 1 | DMA address enable; high blocks selection |
| iorN | input | 1 | Active-low I/O read command |
| iowN | input | 1 | Active-low I/O write command |
| sdIn | input | 8 | Data byte from the bus |
| sdOut | output | 8 | Read data toward the bus |
| sdOe | output | 1 | Output enable for `sdOut` |
| rdyLowEn | output | 1 | Open-drain enable; high pulls channel-ready low |
| devReady | input | 1 | Internal device can finish the cycle |
| cfgLatency | input | 16 | Four 4-bit wait counts, one per register |

## Verification
The checker watches four things on every cycle: that nothing is driven or stretched while `aen` is high or the address misses, that the output enable follows the read strobe, that the ready line is pulled low in the first cycle of a command, and that once it is released during a command it does not fall again. Only the bench scenarios can show the exact wait length for each configured latency, the extended hold while the device is not ready, the write commit on the strobe's rising edge, and the fact that blocked or off-range writes leave the registers unchanged.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;      // capture register index and load the wait counter
    logic dec;       // decrement the wait counter
    logic wrCommit;  // store the bus byte into the latched register
  } ioStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } ioState_t;

endpackage

// File: rtl/isa_io_dpath.sv
module isa_io_dpath
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 2,
  parameter int LAT_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            saAddr,
  input  logic                         aen,
  input  logic [DATA_W-1:0]            sdIn,
  input  logic [(LAT_W<<IDX_W)-1:0]    cfgLatency,
  input  ioStrobes_t                   strb,
  output logic                         hit,
  output logic                         cntZero,
  output logic [DATA_W-1:0]            rdData
);

  localparam int REG_NUM = 1 << IDX_W;

  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  wrIdx;
  logic [LAT_W-1:0]  latSel;
  logic [LAT_W-1:0]  waitCnt;
  logic [DATA_W-1:0] regFile [REG_NUM];

  // Full-width decode; AEN blocks the select during DMA
  assign curIdx = saAddr[IDX_W-1:0];
  assign hit    = (saAddr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]) && !aen;

  always_comb begin
    latSel = '0;
    for (int i = 0; i < REG_NUM; i++) begin
      if (curIdx == i[IDX_W-1:0]) latSel = cfgLatency[i*LAT_W +: LAT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      wrIdx   <= '0;
    end else if (strb.load) begin
      waitCnt <= latSel;
      wrIdx   <= curIdx;
    end else if (strb.dec) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntZero = (waitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_NUM; i++) regFile[i] <= '0;
    end else if (strb.wrCommit) begin
      regFile[wrIdx] <= sdIn;
    end
  end

  assign rdData = regFile[curIdx];

endmodule

// File: rtl/isa_io_ctrl.sv
module isa_io_ctrl
  import isa_io_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hit,
  input  logic       iorN,
  input  logic       iowN,
  input  logic       cntZero,
  input  logic       devReady,
  output ioStrobes_t strb,
  output logic       sdOe,
  output logic       rdyLowEn
);

  ioState_t state, stateNext;
  logic     cmdActive;
  logic     iowPrev;
  logic     wrCycle;

  assign cmdActive = hit && (!iorN || !iowN);

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (cmdActive) begin
          stateNext = ST_WAIT;
          strb.load = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!cmdActive)      stateNext = ST_IDLE;
        else if (!cntZero)   strb.dec  = 1'b1;
        else if (devReady)   stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (!cmdActive) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
    // Commit on the synchronously detected rising edge of the write strobe
    strb.wrCommit = (state != ST_IDLE) && wrCycle && !iowPrev && iowN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iowPrev <= 1'b1;
      wrCycle <= 1'b0;
    end else begin
      state   <= stateNext;
      iowPrev <= iowN;
      if (strb.load) wrCycle <= !iowN;
    end
  end

  // Combinational pull-down: asserted in the very cycle a command appears
  assign rdyLowEn = cmdActive &&
                    ((state == ST_IDLE) ||
                     ((state == ST_WAIT) && !(cntZero && devReady)));

  assign sdOe = hit && !iorN;

endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 2,
  parameter int LAT_W = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         saAddr,
  input  logic                      aen,
  input  logic                      iorN,
  input  logic                      iowN,
  input  logic [DATA_W-1:0]         sdIn,
  output logic [DATA_W-1:0]         sdOut,
  output logic                      sdOe,
  output logic                      rdyLowEn,
  input  logic                      devReady,
  input  logic [(LAT_W<<IDX_W)-1:0] cfgLatency
);

  ioStrobes_t strb;
  logic       hit;
  logic       cntZero;

  isa_io_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .LAT_W(LAT_W), .BASE_ADDR(BASE_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .saAddr(saAddr), .aen(aen), .sdIn(sdIn),
    .cfgLatency(cfgLatency), .strb(strb), .hit(hit), .cntZero(cntZero),
    .rdData(sdOut)
  );

  isa_io_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hit(hit), .iorN(iorN), .iowN(iowN),
    .cntZero(cntZero), .devReady(devReady), .strb(strb),
    .sdOe(sdOe), .rdyLowEn(rdyLowEn)
  );

endmodule

// File: rtl/isa_io_chk.sv
module isa_io_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0300
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] saAddr,
  input logic              aen,
  input logic              iorN,
  input logic              iowN,
  input logic              sdOe,
  input logic              rdyLowEn
);

  logic addrMatch;
  logic cmdSeen;

  assign addrMatch = (saAddr[ADDR_W-1:IDX_W] == BASE_ADDR[ADDR_W-1:IDX_W]);
  assign cmdSeen   = addrMatch && !aen && (!iorN || !iowN);

  // R2: nothing driven or stretched during DMA
  a_r2_dma_quiet: assert property (@(posedge clk) disable iff (!rstN)
    aen |-> (!sdOe && !rdyLowEn));

  // R1: an address miss neither drives nor stretches
  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !addrMatch |-> (!sdOe && !rdyLowEn));

  // R4: output enable only during a read strobe
  a_r4_oe_read_only: assert property (@(posedge clk) disable iff (!rstN)
    sdOe |-> !iorN);

  // R5: ready pulled low in the first cycle of a command
  a_r5_pull_immediate: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSeen && !$past(cmdSeen)) |-> rdyLowEn);

  // R7: once released within a command, stays released
  a_r7_no_repull: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSeen && !rdyLowEn) |=> (!cmdSeen || !rdyLowEn));

endmodule

bind isa_io_slave isa_io_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .saAddr(saAddr), .aen(aen), .iorN(iorN),
  .iowN(iowN), .sdOe(sdOe), .rdyLowEn(rdyLowEn)
);

// File: tb/test_isa_io_slave.sv
`timescale 1ns/1ps
module test_isa_io_slave;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] saAddr = 16'h0000;
  logic        aen = 1'b0;
  logic        iorN = 1'b1;
  logic        iowN = 1'b1;
  logic [7:0]  sdIn = 8'h00;
  logic [7:0]  sdOut;
  logic        sdOe;
  logic        rdyLowEn;
  logic        devReady = 1'b1;
  logic [15:0] cfgLatency = {4'd15, 4'd7, 4'd3, 4'd0};

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  isa_io_slave i_isa_io_slave (
    .clk(clk), .rstN(rstN), .saAddr(saAddr), .aen(aen), .iorN(iorN),
    .iowN(iowN), .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe),
    .rdyLowEn(rdyLowEn), .devReady(devReady), .cfgLatency(cfgLatency)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int latOf(input logic [15:0] a);
    return int'(cfgLatency[a[1:0]*4 +: 4]);
  endfunction

  // Count cycles with ready pulled low, starting from the command cycle
  task automatic countWait(output int n);
    n = 0;
    #1;
    while (rdyLowEn && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, input string req);
    int n;
    @(negedge clk);
    saAddr = a; sdIn = d; iowN = 1'b0;
    countWait(n);
    check(n == latOf(a) + 1, req, n, latOf(a) + 1);
    @(negedge clk); iowN = 1'b1;
    @(negedge clk); saAddr = 16'h0000; sdIn = 8'h00;
  endtask

  task automatic busRead(input logic [15:0] a, input logic [7:0] exp, input string req);
    int n;
    @(negedge clk);
    saAddr = a; iorN = 1'b0;
    countWait(n);
    check(n == latOf(a) + 1, "R6 wait length", n, latOf(a) + 1);
    check(sdOe == 1'b1, "R4 oe during read", sdOe, 1);
    check(sdOut == exp, req, sdOut, exp);
    @(negedge clk); iorN = 1'b1; #1;
    check(sdOe == 1'b0, "R4 oe after read", sdOe, 0);
    saAddr = 16'h0000;
  endtask

  task automatic testReset();
    #1;
    check(!sdOe && !rdyLowEn, "R8 outputs idle after reset", {sdOe, rdyLowEn}, 0);
    for (int i = 0; i < 4; i++) busRead(16'h0300 + 16'(i), 8'h00, "R8 register clear");
  endtask

  task automatic testWriteRead();
    busWrite(16'h0300, 8'hA5, "R6 write wait L=0");
    busWrite(16'h0301, 8'h3C, "R6 write wait L=3");
    busWrite(16'h0302, 8'h7E, "R6 write wait L=7");
    busWrite(16'h0303, 8'hC1, "R6 write wait L=15");
    busRead(16'h0300, 8'hA5, "R3 readback reg0");
    busRead(16'h0301, 8'h3C, "R3 readback reg1");
    busRead(16'h0302, 8'h7E, "R3 readback reg2");
    busRead(16'h0303, 8'hC1, "R3 readback reg3");
  endtask

  task automatic testLatencyChange();
    cfgLatency[7:4] = 4'd5;
    busRead(16'h0301, 8'h3C, "R6 reprogrammed latency");
    cfgLatency[7:4] = 4'd3;
  endtask

  task automatic testDmaBlock();
    @(negedge clk);
    aen = 1'b1; saAddr = 16'h0302; sdIn = 8'h11; iowN = 1'b0; #1;
    check(rdyLowEn == 1'b0, "R2 no wait in DMA write", rdyLowEn, 0);
    @(negedge clk); iowN = 1'b1;
    @(negedge clk); iorN = 1'b0; #1;
    check(sdOe == 1'b0, "R2 no drive in DMA read", sdOe, 0);
    check(rdyLowEn == 1'b0, "R2 no wait in DMA read", rdyLowEn, 0);
    @(negedge clk); iorN = 1'b1; aen = 1'b0; saAddr = 16'h0000;
    busRead(16'h0302, 8'h7E, "R2 DMA write ignored");
  endtask

  task automatic testMiss();
    logic [15:0] misses [3] = '{16'h1300, 16'h0304, 16'h02FF};
    foreach (misses[k]) begin
      @(negedge clk);
      saAddr = misses[k]; sdIn = 8'hEE; iowN = 1'b0; #1;
      check(rdyLowEn == 1'b0, "R1 miss write no wait", rdyLowEn, 0);
      @(negedge clk); iowN = 1'b1;
      @(negedge clk); iorN = 1'b0; #1;
      check(sdOe == 1'b0, "R1 miss read no drive", sdOe, 0);
      @(negedge clk); iorN = 1'b1; saAddr = 16'h0000;
    end
    busRead(16'h0300, 8'hA5, "R1 alias write ignored");
    busRead(16'h0303, 8'hC1, "R1 neighbour write ignored");
  endtask

  task automatic testDeviceHold();
    @(negedge clk);
    devReady = 1'b0;
    saAddr = 16'h0300; iorN = 1'b0; #1;
    check(rdyLowEn == 1'b1, "R5 pulled in first cycle", rdyLowEn, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      check(rdyLowEn == 1'b1, "R7 held while device busy", rdyLowEn, 1);
    end
    devReady = 1'b1; #1;
    check(rdyLowEn == 1'b0, "R7 released on device ready", rdyLowEn, 0);
    @(negedge clk); #1;
    check(rdyLowEn == 1'b0, "R7 stays released", rdyLowEn, 0);
    check(sdOut == 8'hA5, "R4 read data after hold", sdOut, 8'hA5);
    @(negedge clk); iorN = 1'b1; saAddr = 16'h0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteRead();
    testLatencyChange();
    testDmaBlock();
    testMiss();
    testDeviceHold();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule